// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block maps addresses issued by an AXI-side master onto the link-side address space through a small bank of programmable windows. Software programs each window through a word-wide register port: a control word holding the enable, the window type and the low half of a size mask; an AXI base; a 64-bit link target split into two words; and an extended register holding the upper half of the size mask.

The lookup path is purely combinational. It compares the incoming AXI address against every enabled window in parallel. The lowest-numbered matching window wins. On a hit the block returns the window index and type, and a 64-bit link address: the target ORed with the offset bits that the mask leaves free. For configuration-type windows it also returns the bus, device and function routing numbers held in the target's low word.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every window register reads 0, every window is disabled, and no lookup hits.
- R2: Window w has four registers 16 bytes apart, at byte offsets 16*w+0 (control), +4 (AXI base), +8 (link target low word) and +12 (link target high word). Its extended size register is at 0x200+4*w. A written value reads back from the same offset. Writes with a nonzero reg_addr[1:0] are ignored.
- R3: In the control word, bit 0 enables the window and bits 2:1 give the type (0 config, 1 I/O, 2 memory). Bits 31:3 are the low part of the size mask.
- R4: The AXI base register drops bits 1:0. They read back as 0 and never take part in a match.
- R5: The 64-bit mask is {extended size register, control[31:3], 3'b000}. An address hits an enabled window when (addr & mask) == (base & mask), with the address and base zero-extended to 64 bits.
- R6: On a hit, lk_link_addr = {target high, target low} | (addr & ~mask).
- R7: When more than one window matches, the lowest-numbered window supplies every lookup output.
- R8: On a miss, lk_hit, lk_win, lk_type, lk_link_addr and the routing fields are all 0.
- R9: On a hit on a config window, lk_bus = target low[31:24], lk_dev = target low[23:19] and lk_fn = target low[18:16]. For any other type these fields are 0.
- R10: Windows with index at or above ACTIVE_WIN (default 6) reject programming. Their registers read 0 and they never hit.
- R11: A window whose enable bit is 0 never hits, even when its base and mask match the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset, shared by writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| lk_addr | input | AXI_AW | AXI address to translate |
| lk_hit | output | 1 | Address falls in an enabled window |
| lk_win | output | IW | Index of the winning window |
| lk_type | output | 2 | Type of the winning window |
| lk_link_addr | output | 64 | Translated link address |
| lk_bus | output | 8 | Config routing: bus number |
| lk_dev | output | 5 | Config routing: device number |
| lk_fn | output | 3 | Config routing: function number |

## Verification
The assertions check on every cycle that a miss drives all lookup outputs to zero. They also check that routing fields appear only for config-type results, that no window at or above the active limit ever reports a hit, and that no hit appears right after reset. Some behaviours are visible only in the bench's scenarios because they depend on programmed contents. These are register readback and alignment, the mask and substitution arithmetic, lowest-index priority on overlapping windows, and the effect of clearing an enable bit.

// File: rtl/obwin_xlate.sv
module obwin_xlate #(
  parameter int NUM_WIN    = 8,
  parameter int ACTIVE_WIN = 6,
  parameter int AXI_AW     = 32,
  parameter int REG_AW     = 12,
  parameter int EXT_BASE   = 'h200,
  localparam int IW = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [AXI_AW-1:0] lk_addr,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_win,
  output logic [1:0]        lk_type,
  output logic [63:0]       lk_link_addr,
  output logic [7:0]        lk_bus,
  output logic [4:0]        lk_dev,
  output logic [2:0]        lk_fn
);
  localparam logic [REG_AW-1:0] MAIN_END = REG_AW'(NUM_WIN * 16);
  localparam logic [REG_AW-1:0] EXT_LO   = REG_AW'(EXT_BASE);
  localparam logic [REG_AW-1:0] EXT_HI   = REG_AW'(EXT_BASE + 4 * NUM_WIN);
  localparam logic [IW:0]       LIMIT    = (IW+1)'(ACTIVE_WIN);

  logic [31:0] ctrl_q [NUM_WIN];
  logic [31:0] base_q [NUM_WIN];
  logic [31:0] tlo_q  [NUM_WIN];
  logic [31:0] thi_q  [NUM_WIN];
  logic [31:0] ext_q  [NUM_WIN];

  logic              aligned;
  logic [IW-1:0]     main_idx, ext_idx;
  logic [REG_AW-1:0] ext_off;
  logic [1:0]        main_sel;
  logic              main_ok, ext_ok;

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign main_idx = IW'(reg_addr >> 4);
  assign main_sel = reg_addr[3:2];
  assign ext_off  = reg_addr - EXT_LO;
  assign ext_idx  = IW'(ext_off >> 2);
  assign main_ok  = aligned && (reg_addr < MAIN_END) && ({1'b0, main_idx} < LIMIT);
  assign ext_ok   = aligned && (reg_addr >= EXT_LO) && (reg_addr < EXT_HI)
                    && ({1'b0, ext_idx} < LIMIT);

  logic [63:0] addr64;
  assign addr64 = {{(64-AXI_AW){1'b0}}, lk_addr};

  logic [NUM_WIN-1:0] match;
  logic [63:0]        link_w [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [63:0] mask;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[w] <= '0;
        base_q[w] <= '0;
        tlo_q[w]  <= '0;
        thi_q[w]  <= '0;
        ext_q[w]  <= '0;
      end else if (reg_we) begin
        if (main_ok && main_idx == IW'(w)) begin
          case (main_sel)
            2'd0: ctrl_q[w] <= reg_wdata;
            2'd1: base_q[w] <= {reg_wdata[31:2], 2'b00};
            2'd2: tlo_q[w]  <= reg_wdata;
            default: thi_q[w] <= reg_wdata;
          endcase
        end
        if (ext_ok && ext_idx == IW'(w)) ext_q[w] <= reg_wdata;
      end
    end

    assign mask      = {ext_q[w], ctrl_q[w][31:3], 3'b000};
    assign match[w]  = ctrl_q[w][0] && ((addr64 & mask) == ({32'b0, base_q[w]} & mask));
    assign link_w[w] = {thi_q[w], tlo_q[w]} | (addr64 & ~mask);
  end

  always_comb begin
    reg_rdata = '0;
    if (main_ok) begin
      case (main_sel)
        2'd0: reg_rdata = ctrl_q[main_idx];
        2'd1: reg_rdata = base_q[main_idx];
        2'd2: reg_rdata = tlo_q[main_idx];
        default: reg_rdata = thi_q[main_idx];
      endcase
    end else if (ext_ok) begin
      reg_rdata = ext_q[ext_idx];
    end
  end

  logic [31:0] sel_tlo;

  always_comb begin
    lk_hit       = 1'b0;
    lk_win       = '0;
    lk_type      = 2'd0;
    lk_link_addr = '0;
    sel_tlo      = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        lk_hit       = 1'b1;
        lk_win       = IW'(w);
        lk_type      = ctrl_q[w][2:1];
        lk_link_addr = link_w[w];
        sel_tlo      = tlo_q[w];
      end
    end
  end

  logic is_cfg;
  assign is_cfg = lk_hit && (lk_type == 2'd0);
  assign lk_bus = is_cfg ? sel_tlo[31:24] : 8'd0;
  assign lk_dev = is_cfg ? sel_tlo[23:19] : 5'd0;
  assign lk_fn  = is_cfg ? sel_tlo[18:16] : 3'd0;

endmodule

module obwin_xlate_chk #(
  parameter int NUM_WIN    = 8,
  parameter int ACTIVE_WIN = 6,
  localparam int IW = $clog2(NUM_WIN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_hit,
  input logic [IW-1:0] lk_win,
  input logic [1:0]    lk_type,
  input logic [63:0]   lk_link_addr,
  input logic [7:0]    lk_bus,
  input logic [4:0]    lk_dev,
  input logic [2:0]    lk_fn
);
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_link_addr == 64'd0 && lk_type == 2'd0 && lk_win == '0)); // R8

  AST_ROUTE_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_type != 2'd0) |-> (lk_bus == 8'd0 && lk_dev == 5'd0 && lk_fn == 3'd0)); // R9

  AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ({1'b0, lk_win} < (IW+1)'(ACTIVE_WIN))); // R10

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit); // R1
endmodule

bind obwin_xlate obwin_xlate_chk #(.NUM_WIN(NUM_WIN), .ACTIVE_WIN(ACTIVE_WIN)) u_chk (.*);

// File: tb/obwin_xlate_bench.sv
`timescale 1ns/1ps
module obwin_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [2:0]  lk_win;
  logic [1:0]  lk_type;
  logic [63:0] lk_link_addr;
  logic [7:0]  lk_bus;
  logic [4:0]  lk_dev;
  logic [2:0]  lk_fn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  obwin_xlate u_obwin_xlate (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic look(logic [31:0] a);
    @(negedge clk);
    lk_addr = a;
    #1;
  endtask

  task automatic t_reset;
    rd("R1 ctrl0", 12'h000, 32'd0);
    rd("R1 ext0", 12'h200, 32'd0);
    look(32'h0000_0000);
    chk("R1 no hit", {63'd0, lk_hit}, 64'd0);
    chk("R8 miss link", lk_link_addr, 64'd0);
  endtask

  task automatic t_layout;
    wr(12'h000, 32'hFFFF_0005);
    wr(12'h004, 32'h4000_0000);
    wr(12'h008, 32'h8000_0000);
    wr(12'h00C, 32'h0000_0012);
    wr(12'h200, 32'hFFFF_FFFF);
    rd("R2 ctrl", 12'h000, 32'hFFFF_0005);
    rd("R2 tgt lo", 12'h008, 32'h8000_0000);
    rd("R2 tgt hi", 12'h00C, 32'h0000_0012);
    rd("R2 ext", 12'h200, 32'hFFFF_FFFF);
    wr(12'h00E, 32'h1234_5678);
    rd("R2 unaligned ignored", 12'h00C, 32'h0000_0012);
  endtask

  task automatic t_mem;
    look(32'h4000_1234);
    chk("R5 hit", {63'd0, lk_hit}, 64'd1);
    chk("R3 type mem", {62'd0, lk_type}, 64'd2);
    chk("R6 link", lk_link_addr, 64'h0000_0012_8000_1234);
    chk("R9 non-cfg bus", {56'd0, lk_bus}, 64'd0);
    look(32'h4001_0000);
    chk("R8 miss", {63'd0, lk_hit}, 64'd0);
    chk("R8 miss link", lk_link_addr, 64'd0);
  endtask

  task automatic t_priority;
    wr(12'h010, 32'hFFF0_0005);
    wr(12'h014, 32'h4000_0000);
    wr(12'h018, 32'h0000_0000);
    wr(12'h01C, 32'h0000_0034);
    wr(12'h204, 32'hFFFF_FFFF);
    look(32'h4000_1234);
    chk("R7 low wins idx", {61'd0, lk_win}, 64'd0);
    chk("R7 low wins link", lk_link_addr, 64'h0000_0012_8000_1234);
    look(32'h4008_0000);
    chk("R7 win1 idx", {61'd0, lk_win}, 64'd1);
    chk("R6 win1 link", lk_link_addr, 64'h0000_0034_0008_0000);
    wr(12'h000, 32'hFFFF_0004);
    look(32'h4000_1234);
    chk("R11 disabled skipped", {61'd0, lk_win}, 64'd1);
    chk("R11 link", lk_link_addr, 64'h0000_0034_0000_1234);
  endtask

  task automatic t_cfg_io;
    wr(12'h020, 32'hFFFF_F001);
    wr(12'h024, 32'h5000_0003);
    wr(12'h028, 32'h032A_0000);
    wr(12'h208, 32'hFFFF_FFFF);
    rd("R4 base align", 12'h024, 32'h5000_0000);
    look(32'h5000_0ABC);
    chk("R4 hit", {63'd0, lk_hit}, 64'd1);
    chk("R3 type cfg", {62'd0, lk_type}, 64'd0);
    chk("R9 bus", {56'd0, lk_bus}, 64'd3);
    chk("R9 dev", {59'd0, lk_dev}, 64'd5);
    chk("R9 fn", {61'd0, lk_fn}, 64'd2);
    chk("R6 cfg link", lk_link_addr, 64'h0000_0000_032A_0ABC);
    wr(12'h030, 32'hFFFF_F003);
    wr(12'h034, 32'h6000_0000);
    wr(12'h038, 32'h0000_1000);
    wr(12'h20C, 32'hFFFF_FFFF);
    look(32'h6000_0010);
    chk("R3 type io", {62'd0, lk_type}, 64'd1);
    chk("R9 io no dev", {59'd0, lk_dev}, 64'd0);
    chk("R6 io link", lk_link_addr, 64'h0000_0000_0000_1010);
  endtask

  task automatic t_limit;
    wr(12'h060, 32'hFFFF_F005);
    wr(12'h064, 32'h7000_0000);
    wr(12'h218, 32'hFFFF_FFFF);
    rd("R10 ctrl6 reads 0", 12'h060, 32'd0);
    rd("R10 ext6 reads 0", 12'h218, 32'd0);
    look(32'h7000_0000);
    chk("R10 no hit", {63'd0, lk_hit}, 64'd0);
    wr(12'h040, 32'h0000_0005);
    wr(12'h04C, 32'h0000_00AB);
    look(32'h7000_0000);
    chk("R5 catch-all idx", {61'd0, lk_win}, 64'd4);
    chk("R5 catch-all link", lk_link_addr, 64'h0000_00AB_7000_0000);
    look(32'h4000_1234);
    chk("R7 over catch-all", {61'd0, lk_win}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_layout;
    t_mem;
    t_priority;
    t_cfg_io;
    t_limit;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule